// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 single-precision operands and evaluates one of sixteen predicates on them. The predicates combine three relations (unordered, equal, less) in every subset, and each one comes in a quiet form and a signalling form. The one-bit answer is kept in a condition register. The core reads that register back through a small control-register read port, where it sits at index 1.

The core pulses `start` for one cycle with both operands and a 4-bit condition code. On the next cycle three things happen: `done` pulses, the condition bit takes the new result, and `invalid` reports whether the compare raised an invalid-operation exception. Both results hold until the next strobe. Ordering comes straight from the sign-magnitude bit patterns. The two zeros compare equal. Any NaN makes the pair unordered.

Top module: `fpcmp_unit`

## Requirements
- R1: While `rst_n` is low, the next clock edge clears `cond_bit`, `invalid` and `done` to 0.
- R2: `done` is 1 in exactly the cycle after each cycle in which `start` was 1, and is 0 otherwise.
- R3: In `cond_sel[2:0]`, bit 0 adds unordered, bit 1 adds equal and bit 2 adds less. The result is the OR of the selected relations, so code 0 always yields 0.
- R4: Codes 8 to 15 give the same result as the code 8 lower.
- R5: An operand is NaN when its exponent field is all ones and its fraction is non-zero. If either operand is NaN, only the unordered relation is true.
- R6: +0 (0x00000000) and -0 (0x80000000) compare as equal, not less.
- R7: Non-NaN operands are ordered by sign-magnitude value, and infinities take part in this ordering. The two results can differ only in the cases covered by R6.
- R8: When `cond_sel[3]` is 1, `invalid` is 1 for any NaN operand. When `cond_sel[3]` is 0, `invalid` is 1 only for a signalling NaN, which is a NaN whose fraction MSB (bit 22) is 0.
- R9: Without `start`, `cond_bit` and `invalid` keep their values whatever the operand and code inputs do.
- R10: `ccr_rd_data` is combinational. Index 1 returns the condition bit in bit 0 with all other bits zero, and every other index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Compare strobe, one cycle |
| op_a | input | 32 | First operand (left side of the relation) |
| op_b | input | 32 | Second operand |
| cond_sel | input | 4 | Predicate code; bit 3 selects the signalling form |
| ccr_rd_idx | input | 4 | Control-register read index |
| cond_bit | output | 1 | Stored compare result |
| done | output | 1 | Pulses the cycle after `start` |
| invalid | output | 1 | Invalid-operation flag of the last compare |
| ccr_rd_data | output | 32 | Control-register read data |

## Verification
The assertions assume that `start` is sampled as a clean one-cycle strobe and that the operands and code are stable at the clock edge where `start` is high. They make no assumption about the inputs between strobes, and the hold property depends on that. The stimulus changes the operands, the code and the read index only on falling edges. After every compare it drives unrelated values without a strobe, so that this freedom is exercised. The operand set covers zeros of both signs, denormals, normals, the largest finite values, infinities, and quiet and signalling NaNs of both signs. Every pair of these is run against all sixteen codes.

// File: rtl/fpcmp_pkg.sv
// Package: shared types for the compare condition unit.
// Assumes operands follow the IEEE-754 binary layout {sign, exponent, fraction}.
package fpcmp_pkg;

    // Per-operand classification produced by the classifier.
    typedef struct packed {
        logic nan;
        logic snan;
        logic zero;
    } opclass_t;

    // Relation between the two operands; at most one field is set.
    typedef struct packed {
        logic un;
        logic eq;
        logic lt;
    } rel_t;

    // Positions inside the 4-bit condition code.
    localparam int unsigned CODE_UN_BIT  = 0;
    localparam int unsigned CODE_EQ_BIT  = 1;
    localparam int unsigned CODE_LT_BIT  = 2;
    localparam int unsigned CODE_SIG_BIT = 3;
    localparam int unsigned CODE_W       = 4;

    // Named predicates of the lower three code bits.
    typedef enum logic [2:0] {
        PRED_NEVER = 3'd0,
        PRED_UN    = 3'd1,
        PRED_EQ    = 3'd2,
        PRED_UEQ   = 3'd3,
        PRED_LT    = 3'd4,
        PRED_ULT   = 3'd5,
        PRED_LE    = 3'd6,
        PRED_ULE   = 3'd7
    } pred_e;

endpackage

// File: rtl/fpcmp_classify.sv
// Module: fpcmp_classify
// Sorts one operand into NaN, signalling NaN and zero of either sign.
// Assumes the fraction MSB set marks a quiet NaN.
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] op,
    output opclass_t             cls
);
    localparam int unsigned DATA_W = EXP_W + MAN_W + 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             exp_zero;
    logic             man_zero;

    // Split the operand into its fields.
    always_comb begin
        exp_f = op[DATA_W-2 -: EXP_W];
        man_f = op[MAN_W-1:0];
    end

    // Field summaries.
    always_comb begin
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        man_zero = ~|man_f;
    end

    // Classification flags.
    always_comb begin
        cls.nan  = exp_ones & ~man_zero;
        cls.snan = exp_ones & ~man_zero & ~man_f[MAN_W-1];
        cls.zero = exp_zero & man_zero;
    end

endmodule

// File: rtl/fpcmp_order.sv
// Module: fpcmp_order
// Finds the relation of operand A to operand B by comparing sign and magnitude bits.
// Assumes the NaN and zero flags come from fpcmp_classify for the same operands.
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  logic                 nan_a,
    input  logic                 nan_b,
    input  logic                 zero_a,
    input  logic                 zero_b,
    output rel_t                 rel
);
    localparam int unsigned DATA_W = EXP_W + MAN_W + 1;
    localparam int unsigned MAG_W  = DATA_W - 1;

    logic             sign_a;
    logic             sign_b;
    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             mag_lt;
    logic             mag_eq;

    // Separate sign and magnitude.
    always_comb begin
        sign_a = op_a[DATA_W-1];
        sign_b = op_b[DATA_W-1];
        mag_a  = op_a[MAG_W-1:0];
        mag_b  = op_b[MAG_W-1:0];
    end

    // Unsigned magnitude comparison.
    always_comb begin
        mag_lt = mag_a < mag_b;
        mag_eq = mag_a == mag_b;
    end

    // Resolve the relation: NaN first, then zeros, then signs, then magnitudes.
    always_comb begin
        rel = '0;
        if (nan_a | nan_b) begin
            rel.un = 1'b1;
        end else if (zero_a & zero_b) begin
            rel.eq = 1'b1;
        end else if (sign_a != sign_b) begin
            rel.lt = sign_a;
        end else if (!sign_a) begin
            rel.lt = mag_lt;
            rel.eq = mag_eq;
        end else begin
            rel.lt = ~mag_lt & ~mag_eq;
            rel.eq = mag_eq;
        end
    end

endmodule

// File: rtl/fpcmp_predicate.sv
// Module: fpcmp_predicate
// Applies the condition code to the relation and derives the invalid-operation flag.
// Assumes at most one relation field is set.
module fpcmp_predicate
    import fpcmp_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  rel_t              rel,
    input  logic              snan_a,
    input  logic              snan_b,
    output logic              result,
    output logic              invalid
);
    pred_e pred;
    logic  signalling;

    // Decode the code into predicate and signalling form.
    always_comb begin
        pred       = pred_e'(code[CODE_LT_BIT:CODE_UN_BIT]);
        signalling = code[CODE_SIG_BIT];
    end

    // Evaluate the predicate; PRED_NEVER still passes through exception logic.
    always_comb begin
        unique case (pred)
            PRED_NEVER: result = 1'b0;
            PRED_UN:    result = rel.un;
            PRED_EQ:    result = rel.eq;
            PRED_UEQ:   result = rel.un | rel.eq;
            PRED_LT:    result = rel.lt;
            PRED_ULT:   result = rel.un | rel.lt;
            PRED_LE:    result = rel.lt | rel.eq;
            PRED_ULE:   result = rel.un | rel.lt | rel.eq;
            default:    result = 1'b0;
        endcase
    end

    // Invalid: any signalling NaN, or any NaN under a signalling code.
    always_comb begin
        invalid = snan_a | snan_b | (signalling & rel.un);
    end

endmodule

// File: rtl/fpcmp_unit.sv
// Module: fpcmp_unit (top)
// Registers a floating-point compare result on the cycle after start and
// exposes it at control-register index 1. Assumes start is a single-cycle strobe.
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int unsigned EXP_W      = 8,
    parameter int unsigned MAN_W      = 23,
    parameter int unsigned CCR_IDX_W  = 4,
    parameter int unsigned CCR_DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [EXP_W+MAN_W:0]    op_a,
    input  logic [EXP_W+MAN_W:0]    op_b,
    input  logic [CODE_W-1:0]       cond_sel,
    input  logic [CCR_IDX_W-1:0]    ccr_rd_idx,
    output logic                    cond_bit,
    output logic                    done,
    output logic                    invalid,
    output logic [CCR_DATA_W-1:0]   ccr_rd_data
);
    localparam int unsigned DATA_W   = EXP_W + MAN_W + 1;
    localparam int unsigned N_OPS    = 2;
    localparam logic [CCR_IDX_W-1:0] COND_IDX = CCR_IDX_W'(1);

    logic [DATA_W-1:0] ops [N_OPS];
    opclass_t          cls [N_OPS];
    rel_t              rel;
    logic              res_d;
    logic              inv_d;
    logic              cond_q;
    logic              inv_q;
    logic              done_q;

    // Gather operands for the classifier array.
    always_comb begin
        ops[0] = op_a;
        ops[1] = op_b;
    end

    // One classifier per operand.
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .op  (ops[gi]),
            .cls (cls[gi])
        );
    end

    fpcmp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
        .op_a   (op_a),
        .op_b   (op_b),
        .nan_a  (cls[0].nan),
        .nan_b  (cls[1].nan),
        .zero_a (cls[0].zero),
        .zero_b (cls[1].zero),
        .rel    (rel)
    );

    fpcmp_predicate u_pred (
        .code    (cond_sel),
        .rel     (rel),
        .snan_a  (cls[0].snan),
        .snan_b  (cls[1].snan),
        .result  (res_d),
        .invalid (inv_d)
    );

    // Capture result and flag on a strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            inv_q  <= 1'b0;
        end else if (start) begin
            cond_q <= res_d;
            inv_q  <= inv_d;
        end
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= start;
    end

    // Control-register read port.
    always_comb begin
        ccr_rd_data = '0;
        if (ccr_rd_idx == COND_IDX) ccr_rd_data[0] = cond_q;
    end

    // Drive outputs.
    always_comb begin
        cond_bit = cond_q;
        invalid  = inv_q;
        done     = done_q;
    end

endmodule

// File: rtl/fpcmp_unit_chk.sv
// Module: fpcmp_unit_chk
// Port-level properties of fpcmp_unit, attached by bind below.
module fpcmp_unit_chk #(
    parameter int unsigned EXP_W      = 8,
    parameter int unsigned MAN_W      = 23,
    parameter int unsigned CCR_IDX_W  = 4,
    parameter int unsigned CCR_DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic [EXP_W+MAN_W:0]  op_a,
    input logic [EXP_W+MAN_W:0]  op_b,
    input logic [3:0]            cond_sel,
    input logic [CCR_IDX_W-1:0]  ccr_rd_idx,
    input logic                  cond_bit,
    input logic                  done,
    input logic                  invalid,
    input logic [CCR_DATA_W-1:0] ccr_rd_data
);
    logic nan_a;
    logic nan_b;

    // Independent NaN detection from the ports.
    always_comb begin
        nan_a = (&op_a[EXP_W+MAN_W-1:MAN_W]) && (op_a[MAN_W-1:0] != '0);
        nan_b = (&op_b[EXP_W+MAN_W-1:MAN_W]) && (op_b[MAN_W-1:0] != '0);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!cond_bit && !invalid && !done)); // R1
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R2
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(start)); // R2
    AST_NEVER_PRED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (start && cond_sel[2:0] == 3'd0) |=> !cond_bit); // R3
    AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n) (start && (nan_a || nan_b)) |=> (cond_bit == $past(cond_sel[0]))); // R5
    AST_SIG_NAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n) (start && cond_sel[3] && (nan_a || nan_b)) |=> invalid); // R8
    AST_ORDERED_NO_INVALID: assert property (@(posedge clk) disable iff (!rst_n) (start && !nan_a && !nan_b) |=> !invalid); // R8
    AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n) !start |=> ($stable(cond_bit) && $stable(invalid))); // R9
    AST_READBACK_IDX1: assert property (@(posedge clk) disable iff (!rst_n) (ccr_rd_idx == CCR_IDX_W'(1)) |-> (ccr_rd_data == {{(CCR_DATA_W-1){1'b0}}, cond_bit})); // R10

endmodule

bind fpcmp_unit fpcmp_unit_chk #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .CCR_IDX_W(CCR_IDX_W), .CCR_DATA_W(CCR_DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .cond_sel(cond_sel), .ccr_rd_idx(ccr_rd_idx), .cond_bit(cond_bit),
    .done(done), .invalid(invalid), .ccr_rd_data(ccr_rd_data)
);

// File: tb/fpcmp_unit_bench.sv
module fpcmp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  cond_sel = '0;
    logic [3:0]  ccr_rd_idx = '0;
    logic        cond_bit;
    logic        done;
    logic        invalid;
    logic [31:0] ccr_rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fpcmp_unit u_fpcmp_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .cond_sel(cond_sel), .ccr_rd_idx(ccr_rd_idx), .cond_bit(cond_bit),
        .done(done), .invalid(invalid), .ccr_rd_data(ccr_rd_data)
    );

    function automatic logic [31:0] pick(input int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h8000_0000;
            2: return 32'h3F80_0000;  3: return 32'hBF80_0000;
            4: return 32'h4000_0000;  5: return 32'hC000_0000;
            6: return 32'h0000_0001;  7: return 32'h8000_0001;
            8: return 32'h7F80_0000;  9: return 32'hFF80_0000;
            10: return 32'h7F7F_FFFF; 11: return 32'hFF7F_FFFF;
            12: return 32'h7FC0_0000; 13: return 32'h7F80_0001;
            14: return 32'hFFC0_0001; default: return 32'hFFA0_0000;
        endcase
    endfunction

    function automatic bit is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic longint key(input logic [31:0] v);
        longint m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (a=%h b=%h code=%0d)", req, act, exp, op_a, op_b, cond_sel);
        end
    endtask

    task automatic run_cmp(input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
        bit un, eq, lt, res, inv, snan;
        string tag;
        un = is_nan(a) || is_nan(b);
        eq = !un && (key(a) == key(b));
        lt = !un && (key(a) < key(b));
        res = (c[0] && un) || (c[1] && eq) || (c[2] && lt);
        snan = (is_nan(a) && !a[22]) || (is_nan(b) && !b[22]);
        inv = snan || (c[3] && un);
        if (c[3])                      tag = "R4";
        else if (un)                   tag = "R5";
        else if (key(a) == 0 && key(b) == 0 && a != b) tag = "R6";
        else if (c[2:0] == 3'd0)       tag = "R3";
        else                           tag = "R7";
        @(negedge clk);
        op_a = a; op_b = b; cond_sel = c; start = 1'b1; ccr_rd_idx = 4'd1;
        @(negedge clk);
        start = 1'b0;
        check("R2", {31'b0, done}, 32'd1);
        check(tag, {31'b0, cond_bit}, {31'b0, res});
        check("R8", {31'b0, invalid}, {31'b0, inv});
        check("R10", ccr_rd_data, {31'b0, res});
        op_a = ~a; op_b = a; cond_sel = ~c; ccr_rd_idx = {c[0], 3'b000} | 4'd2;
        @(negedge clk);
        check("R2", {31'b0, done}, 32'd0);
        check("R9", {31'b0, cond_bit}, {31'b0, res});
        check("R9", {31'b0, invalid}, {31'b0, inv});
        check("R10", ccr_rd_data, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {29'b0, cond_bit, invalid, done}, 32'd0);
        rst_n = 1'b1;
        for (int ia = 0; ia < 16; ia++)
            for (int ib = 0; ib < 16; ib++)
                for (int c = 0; c < 16; c++)
                    run_cmp(pick(ia), pick(ib), 4'(c));
        run_cmp(32'h7FC0_0000, 32'h0, 4'd9);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {29'b0, cond_bit, invalid, done}, 32'd0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule